// File: doc/BRIEF.md
# Majority Coincidence Trigger

This block produces a board-level common trigger from a set of digitized sample streams. Every channel compares its sample against its own threshold. The comparison can look for samples above the threshold or for samples below it. Adjacent channels are merged two by two into pair requests. The enabled pair requests then go through a coincidence unit, where each request can be stretched over a programmable validation window. The unit fires when more requests overlap than the programmed majority level.

A majority level of zero turns coincidence off, and any enabled pair request then fires the trigger directly. An asynchronous external trigger line and a software strobe can also fire the trigger. Each of them has its own enable. The output is a one-cycle pulse, and the pair requests are brought out for monitoring.

Top module: `coin_trig_top`

## Requirements
- R1: A channel is active when its unsigned sample is strictly greater than its threshold while `polarity_i` is 0. It is active when the sample is strictly less than the threshold while `polarity_i` is 1. The result is registered once.
- R2: `pair_req_o[p]` is the OR of channels 2p and 2p+1. It is valid one clock after the sample is presented.
- R3: With `level_i` = 0, any enabled pair request produces a common trigger two clocks after the sample. `window_i` has no effect in this mode.
- R4: With `level_i` ≥ 1 and `window_i` = 0, the trigger fires only when more than `level_i` enabled pair requests are high in the same cycle.
- R5: With `window_i` = W > 0, a rising pair request counts as active for W cycles, starting in the cycle it rises. The trigger fires when the number of active enabled requests exceeds `level_i`.
- R6: A pair whose bit in `pair_en_i` is 0 never contributes to the common trigger.
- R7: When `ext_en_i` is 1, each rising edge of `ext_trig_i` gives exactly one common trigger, three clocks later. The input passes through a two-flop synchronizer and an edge detector. When `ext_en_i` is 0, the line has no effect.
- R8: When `sw_en_i` is 1, each rising edge of `sw_trig_i` gives exactly one common trigger on the next clock. When `sw_en_i` is 0, the strobe has no effect.
- R9: `common_trig_o` is a single-cycle pulse and is never high in two consecutive cycles. After a coincidence trigger, the unit cannot fire again until the active count has fallen to `level_i` or below.
- R10: During reset and right after it, `common_trig_o` and `pair_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samples_i | input | N_CH*SAMPLE_W | Packed channel samples, channel 0 in the low bits |
| thresh_i | input | N_CH*SAMPLE_W | Packed per-channel thresholds |
| polarity_i | input | 1 | 0 fires above the threshold, 1 fires below it |
| pair_en_i | input | N_CH/2 | Pair request enable mask |
| ext_en_i | input | 1 | External trigger enable |
| sw_en_i | input | 1 | Software trigger enable |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| sw_trig_i | input | 1 | Software trigger strobe |
| level_i | input | LVL_W | Majority level (0 gives plain OR) |
| window_i | input | WIN_W | Validation window in clocks (0 means same cycle) |
| common_trig_o | output | 1 | Common trigger pulse |
| pair_req_o | output | N_CH/2 | Per-pair trigger requests |

## Verification
The coincidence path is driven in several ways: single pulses on one pair, pairs raised in the same cycle, and pairs raised a set number of cycles apart. Delays of three and four cycles against a window of four show where the stretched request ends. A delay of one cycle with a zero window shows that zero means exact overlap. Level 0 is contrasted with levels 1 and 2, and masked pairs are used to separate the enable mask from the count. Held requests show that the unit fires once and re-arms only when the count falls. Held external and software inputs show that both are edge-triggered and that their enables gate them.

// File: rtl/coin_pkg.sv
package coin_pkg;

    typedef enum logic {
        POL_ABOVE = 1'b0,
        POL_BELOW = 1'b1
    } pol_e;

endpackage

// File: rtl/chan_disc.sv
module chan_disc #(
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [SAMPLE_W-1:0] thresh_i,
    input  coin_pkg::pol_e      pol_i,
    output logic                hit_o
);
    typedef struct packed {
        logic hit;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pol_i == coin_pkg::POL_BELOW) st_d.hit = (sample_i < thresh_i);
        else                              st_d.hit = (sample_i > thresh_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = st_q.hit;
endmodule

// File: rtl/pair_stretch.sv
module pair_stretch #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [WIN_W-1:0] window_i,
    output logic             act_o
);
    typedef struct packed {
        logic             prev;
        logic [WIN_W-1:0] left;
    } st_t;

    st_t  st_d, st_q;
    logic rise;

    always_comb begin
        st_d      = st_q;
        rise      = req_i & ~st_q.prev;
        st_d.prev = req_i;
        if (rise && window_i != '0)  st_d.left = WIN_W'(window_i - 1'b1);
        else if (st_q.left != '0)    st_d.left = WIN_W'(st_q.left - 1'b1);
        if (window_i == '0) act_o = req_i;
        else                act_o = rise | (st_q.left != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], async_i};
        st_d.prev = st_q.pipe[STAGES-1];
        rise_o    = st_q.pipe[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/coin_trig_top.sv
module coin_trig_top #(
    parameter int N_CH     = 8,
    parameter int SAMPLE_W = 14,
    parameter int WIN_W    = 8,
    parameter int N_PAIR   = N_CH / 2,
    parameter int LVL_W    = $clog2(N_PAIR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH*SAMPLE_W-1:0] samples_i,
    input  logic [N_CH*SAMPLE_W-1:0] thresh_i,
    input  logic                     polarity_i,
    input  logic [N_PAIR-1:0]        pair_en_i,
    input  logic                     ext_en_i,
    input  logic                     sw_en_i,
    input  logic                     ext_trig_i,
    input  logic                     sw_trig_i,
    input  logic [LVL_W-1:0]         level_i,
    input  logic [WIN_W-1:0]         window_i,
    output logic                     common_trig_o,
    output logic [N_PAIR-1:0]        pair_req_o
);
    localparam int CNT_W = $clog2(N_PAIR + 1);

    typedef struct packed {
        logic common;
        logic armed;
        logic sw_prev;
    } st_t;

    st_t                 st_d, st_q;
    logic [N_CH-1:0]     ch_hit;
    logic [N_PAIR-1:0]   pair_act;
    logic                ext_rise;
    logic [CNT_W-1:0]    act_cnt;
    logic                coin_hit;
    logic                trig_any;

    coin_pkg::pol_e pol;
    assign pol = coin_pkg::pol_e'(polarity_i);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        chan_disc #(.SAMPLE_W(SAMPLE_W)) u_disc (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (samples_i[c*SAMPLE_W +: SAMPLE_W]),
            .thresh_i (thresh_i[c*SAMPLE_W +: SAMPLE_W]),
            .pol_i    (pol),
            .hit_o    (ch_hit[c])
        );
    end

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        assign pair_req_o[p] = ch_hit[2*p] | ch_hit[2*p+1];
        pair_stretch #(.WIN_W(WIN_W)) u_str (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (pair_req_o[p]),
            .window_i (window_i),
            .act_o    (pair_act[p])
        );
    end

    edge_sync #(.STAGES(2)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_trig_i),
        .rise_o  (ext_rise)
    );

    always_comb begin
        st_d    = st_q;
        act_cnt = '0;
        for (int p = 0; p < N_PAIR; p++) begin
            act_cnt = act_cnt + CNT_W'(pair_act[p] & pair_en_i[p]);
        end
        if (level_i == '0) coin_hit = |(pair_req_o & pair_en_i);
        else               coin_hit = (act_cnt > CNT_W'(level_i));

        trig_any = (coin_hit & st_q.armed)
                 | (ext_en_i & ext_rise)
                 | (sw_en_i & sw_trig_i & ~st_q.sw_prev);

        st_d.common  = trig_any & ~st_q.common;
        st_d.armed   = ~coin_hit;
        st_d.sw_prev = sw_trig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{common: 1'b0, armed: 1'b1, sw_prev: 1'b0};
        else        st_q <= st_d;
    end

    assign common_trig_o = st_q.common;
endmodule

// File: rtl/coin_trig_chk.sv
module coin_trig_chk #(
    parameter int N_PAIR = 4,
    parameter int LVL_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PAIR-1:0] pair_en_i,
    input logic              ext_en_i,
    input logic              sw_en_i,
    input logic              sw_trig_i,
    input logic [LVL_W-1:0]  level_i,
    input logic              common_trig_o
);
    // R9: never high two cycles in a row
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        common_trig_o |=> !common_trig_o);

    // R6: nothing enabled means no trigger
    a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en_i == '0 && !ext_en_i && !sw_en_i) |=> !common_trig_o);

    // R4: too few enabled pairs to reach the majority
    a_r4_too_few_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i != '0 && $countones(pair_en_i) <= int'(level_i) && !ext_en_i && !sw_en_i)
        |=> !common_trig_o);

    // R8: enabled software edge fires next cycle
    a_r8_sw_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en_i && $rose(sw_trig_i) && !common_trig_o) |=> common_trig_o);
endmodule

bind coin_trig_top coin_trig_chk #(.N_PAIR(N_PAIR), .LVL_W(LVL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pair_en_i     (pair_en_i),
    .ext_en_i      (ext_en_i),
    .sw_en_i       (sw_en_i),
    .sw_trig_i     (sw_trig_i),
    .level_i       (level_i),
    .common_trig_o (common_trig_o)
);

// File: tb/coin_trig_top_bench.sv
module coin_trig_top_bench;
    localparam int N_CH = 8, SW = 14, WW = 8, NP = 4, LW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N_CH*SW-1:0] samples, thresh;
    logic polarity = 1'b0;
    logic [NP-1:0] pair_en = '1;
    logic ext_en = 1'b0, sw_en = 1'b0, ext_trig = 1'b0, sw_trig = 1'b0;
    logic [LW-1:0] level = '0;
    logic [WW-1:0] window = '0;
    logic common;
    logic [NP-1:0] pair_req;

    int checks = 0, errors = 0;
    int obs_idx, obs_cnt, obs_first;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    coin_trig_top u_coin_trig_top (
        .clk(clk), .rst_n(rst_n), .samples_i(samples), .thresh_i(thresh),
        .polarity_i(polarity), .pair_en_i(pair_en), .ext_en_i(ext_en),
        .sw_en_i(sw_en), .ext_trig_i(ext_trig), .sw_trig_i(sw_trig),
        .level_i(level), .window_i(window), .common_trig_o(common),
        .pair_req_o(pair_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input int v);
        samples[ch*SW +: SW] = SW'(v);
    endtask

    task automatic quiet();
        for (int c = 0; c < N_CH; c++) set_ch(c, 500);
        ext_trig = 1'b0; sw_trig = 1'b0;
        repeat (12) @(negedge clk);
        obs_idx = 0; obs_cnt = 0; obs_first = -1;
    endtask

    task automatic tick();
        @(negedge clk);
        obs_idx++;
        if (common) begin
            obs_cnt++;
            if (obs_first < 0) obs_first = obs_idx;
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic t_reset();
        chk(common == 1'b0, "R10 common in reset", int'(common), 0);
        chk(pair_req == '0, "R10 pair_req in reset", int'(pair_req), 0);
    endtask

    task automatic t_threshold_pair();
        level = 0; window = 0; pair_en = '1; polarity = 0;
        quiet();
        set_ch(3, 1000); tick();
        chk(pair_req == 4'b0000, "R1 equal to threshold is not above", int'(pair_req), 0);
        set_ch(3, 1001); tick();
        chk(pair_req == 4'b0010, "R2 odd channel drives its pair", int'(pair_req), 2);
        set_ch(3, 500); ticks(12);
        polarity = 1; quiet();
        for (int c = 0; c < N_CH; c++) set_ch(c, 2000);
        set_ch(4, 999); tick();
        chk(pair_req == 4'b0100, "R1 below-threshold polarity", int'(pair_req), 4);
        for (int c = 0; c < N_CH; c++) set_ch(c, 500);
        polarity = 0; ticks(12);
    endtask

    task automatic t_level0();
        level = 0; window = 8'd4; pair_en = '1;
        quiet();
        set_ch(0, 1500); tick(); set_ch(0, 500); ticks(8);
        chk(obs_first == 2, "R3 level 0 latency", obs_first, 2);
        chk(obs_cnt == 1, "R3 level 0 single pulse, window ignored", obs_cnt, 1);
    endtask

    task automatic t_masked();
        level = 0; window = 0; pair_en = 4'b1110;
        quiet();
        set_ch(1, 1500); tick(); set_ch(1, 500); ticks(6);
        chk(obs_cnt == 0, "R6 masked pair at level 0", obs_cnt, 0);
        level = 1; quiet();
        set_ch(0, 1500); set_ch(2, 1500); tick();
        set_ch(0, 500); set_ch(2, 500); ticks(6);
        chk(obs_cnt == 0, "R6 masked pair not counted", obs_cnt, 0);
        pair_en = '1;
    endtask

    task automatic t_window0();
        level = 1; window = 0; pair_en = '1;
        quiet();
        set_ch(0, 1500); set_ch(2, 1500); tick();
        set_ch(0, 500); set_ch(2, 500); ticks(6);
        chk(obs_first == 2 && obs_cnt == 1, "R4 same-cycle pair fires", obs_first, 2);
        quiet();
        set_ch(0, 1500); tick(); set_ch(0, 500); set_ch(2, 1500); tick();
        set_ch(2, 500); ticks(6);
        chk(obs_cnt == 0, "R4 one cycle apart with zero window", obs_cnt, 0);
    endtask

    task automatic t_level2();
        level = 2; window = 0; pair_en = '1;
        quiet();
        set_ch(0, 1500); set_ch(2, 1500); tick();
        set_ch(0, 500); set_ch(2, 500); ticks(6);
        chk(obs_cnt == 0, "R4 two pairs below level 2", obs_cnt, 0);
        quiet();
        set_ch(0, 1500); set_ch(2, 1500); set_ch(5, 1500); tick();
        set_ch(0, 500); set_ch(2, 500); set_ch(5, 500); ticks(6);
        chk(obs_cnt == 1, "R4 three pairs above level 2", obs_cnt, 1);
    endtask

    task automatic t_window(input int d, input int exp_cnt);
        level = 1; window = 8'd4; pair_en = '1;
        quiet();
        set_ch(0, 1500); tick(); set_ch(0, 500);
        ticks(d - 1);
        set_ch(2, 1500); tick(); set_ch(2, 500); ticks(8);
        chk(obs_cnt == exp_cnt, $sformatf("R5 second pair %0d cycles later, window 4", d), obs_cnt, exp_cnt);
        if (exp_cnt == 1)
            chk(obs_first == d + 2, "R5 stretched coincidence latency", obs_first, d + 2);
    endtask

    task automatic t_rearm();
        level = 1; window = 0; pair_en = '1;
        quiet();
        set_ch(0, 1500); set_ch(2, 1500); ticks(8);
        chk(obs_cnt == 1, "R9 held coincidence fires once", obs_cnt, 1);
        set_ch(2, 500); ticks(3);
        set_ch(2, 1500); ticks(6);
        chk(obs_cnt == 2, "R9 re-arm after count drops", obs_cnt, 2);
        set_ch(0, 500); set_ch(2, 500);
    endtask

    task automatic t_ext();
        level = 0; pair_en = '0; ext_en = 1;
        quiet();
        ext_trig = 1; ticks(5); ext_trig = 0; ticks(4);
        chk(obs_first == 3 && obs_cnt == 1, "R7 external edge fires once after sync", obs_first, 3);
        ext_en = 0; quiet();
        ext_trig = 1; ticks(5); ext_trig = 0; ticks(4);
        chk(obs_cnt == 0, "R7 external disabled", obs_cnt, 0);
    endtask

    task automatic t_sw();
        sw_en = 1; quiet();
        sw_trig = 1; ticks(4); sw_trig = 0; ticks(3);
        chk(obs_first == 1 && obs_cnt == 1, "R8 software edge fires once", obs_first, 1);
        sw_en = 0; quiet();
        sw_trig = 1; ticks(4); sw_trig = 0; ticks(3);
        chk(obs_cnt == 0, "R8 software disabled", obs_cnt, 0);
        pair_en = '1;
    endtask

    initial begin
        for (int c = 0; c < N_CH; c++) begin
            samples[c*SW +: SW] = SW'(500);
            thresh[c*SW +: SW]  = SW'(1000);
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold_pair();
        t_level0();
        t_masked();
        t_window0();
        t_level2();
        t_window(3, 1);
        t_window(4, 0);
        t_rearm();
        t_ext();
        t_sw();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule